// File: doc/BRIEF.md
# Power-Fail Memory Guard

This block sits between a host bus and a byte-wide static RAM and keeps the RAM contents safe while the supply collapses or comes back. It receives digitised supply-monitor flags: one flag for each of two selectable trip bands, and one flag that says the supply has dropped below the battery switchover level. From these and the host's active-low chip enable, output enable and write enable, it produces the gated RAM enables, a battery-select output and a mode code.

When the selected trip flag rises, the block enters a pending window. Accesses still pass during this window, so a write that is already running can finish. After the window the RAM is deselected and all host controls are ignored. A lower threshold moves the block into battery backup. When the supply returns, host enables stay ignored for a recovery window, and then normal decoding resumes. All windows are counted in clock cycles by one free-running counter.

A small behavioural byte array is included so that the gating can be checked end to end. To keep elaboration small, it folds the 17-bit address into fewer index bits.

Top module: `pwrfail_guard`

## Requirements
- R1: In mode 0 (normal), with `host_ce_n` high, `ram_ce_n`, `ram_we_n` and `ram_oe_n` are all high and `dq_drive` is 0, whatever the states of write enable and output enable.
- R2: In mode 0 or 1, `host_ce_n` low with `host_we_n` low is a write, whatever the state of `host_oe_n`. `ram_we_n` is low, `dq_drive` is 0, and at the clock edge `dq_in` is stored. The stored index is formed by XOR-ing address bit i into index bit (i mod ARRAY_AW), with ARRAY_AW = 10 by default.
- R3: In mode 0 or 1, `host_ce_n` low, `host_we_n` high and `host_oe_n` low drive the stored byte on `dq_out` with `dq_drive` = 1. With `host_oe_n` high, `dq_drive` stays 0 and `dq_out` is 0.
- R4: `mode` uses 0 = normal, 1 = protect pending, 2 = protected, 3 = battery backup, 4 = recovering. Each flag passes through two flops, so a flag change shows in `mode` on the third rising edge after it.
- R5: When the selected trip flag is seen, the block goes from mode 0 to mode 1 and stays there for at least PROT_MIN_CYC cycles. Accesses pass during mode 1. With no write active, it moves to mode 2 after exactly PROT_MIN_CYC cycles. If the trip flag clears while in mode 1, it returns to mode 0.
- R6: A write that is active (`host_ce_n` and `host_we_n` both low) holds mode 1 past PROT_MIN_CYC until the write ends. Mode 1 never lasts more than PROT_MAX_CYC cycles.
- R7: In modes 2, 3 and 4, all RAM enables are high, `dq_drive` is 0, and the array is not modified.
- R8: When the battery flag is seen, the block enters mode 3 from any mode. The battery flag takes priority over the trip flag. `batt_sel` is 1 exactly in mode 3.
- R9: When the battery flag clears, the block leaves mode 3. It goes to mode 2 if the trip flag is still set, and to mode 4 if the trip flag is clear.
- R10: Mode 4 starts its count from zero and returns to mode 0 after REC_CYC cycles. If the trip flag is seen during mode 4, the block returns directly to mode 2.
- R11: `band_sel` = 0 uses `sup_below_hi` as the trip flag. `band_sel` = 1 uses `sup_below_lo`. The flag that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_below_hi | input | 1 | Supply below the upper-band trip point |
| sup_below_lo | input | 1 | Supply below the lower-band trip point |
| sup_below_batt | input | 1 | Supply below the battery switchover level |
| band_sel | input | 1 | Trip band select (0 upper, 1 lower) |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| addr | input | 17 | Byte address |
| dq_in | input | 8 | Write data from host |
| dq_out | output | 8 | Read data to host (0 when not driven) |
| dq_drive | output | 1 | Data lines driven by the memory |
| ram_ce_n | output | 1 | Gated RAM chip enable, active low |
| ram_we_n | output | 1 | Gated RAM write enable, active low |
| ram_oe_n | output | 1 | Gated RAM output enable, active low |
| batt_sel | output | 1 | Battery select |
| mode | output | 3 | Current mode code |

## Verification
The bench drives every decode combination of the three host enables in normal mode. A write with output enable low separates write-dominates decoding from read decoding, and an address with bit 10 set separates address folding from truncation. Trip sequences are run with no write, with a write held for the whole pending window, and with a write that ends between the minimum and maximum limits; these separate the minimum-delay, write-extension and hard-limit exits. Battery and trip flags are raised together and released in both orders, and a trip is re-raised during recovery, which exposes priority and exit-path errors. The unselected band flag is toggled on its own to show that band selection is done correctly.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;

    localparam int ADDR_W   = 17;
    localparam int DATA_W   = 8;
    localparam int ARRAY_AW = 10;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_PEND   = 3'd1,
        MODE_PROT   = 3'd2,
        MODE_BATT   = 3'd3,
        MODE_RECOV  = 3'd4
    } pwr_mode_e;

    typedef struct packed {
        logic batt;
        logic trip_lo;
        logic trip_hi;
    } sup_flags_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ram_ctl_t;

    function automatic logic access_open(input pwr_mode_e m);
        return (m == MODE_NORMAL) || (m == MODE_PEND);
    endfunction

endpackage

// File: rtl/pwrfail_sync.sv
module pwrfail_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/pwrfail_seq.sv
module pwrfail_seq
    import pwrfail_pkg::*;
#(
    parameter int PROT_MIN_CYC = 5000,
    parameter int PROT_MAX_CYC = 18750,
    parameter int REC_CYC      = 5000000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trip,
    input  logic      batt,
    input  logic      wr_active,
    output pwr_mode_e mode,
    output logic      batt_sel
);
    localparam int CNT_TOP = (PROT_MAX_CYC > REC_CYC) ? PROT_MAX_CYC : REC_CYC;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] CNT_SAT  = {CW{1'b1}};
    localparam logic [CW-1:0] MIN_LAST = CW'(PROT_MIN_CYC - 1);
    localparam logic [CW-1:0] MAX_LAST = CW'(PROT_MAX_CYC - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CYC - 1);

    pwr_mode_e     state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        if (batt) begin
            state_d = MODE_BATT;
        end else begin
            unique case (state_q)
                MODE_NORMAL: if (trip) state_d = MODE_PEND;
                MODE_PEND: begin
                    if (!trip)
                        state_d = MODE_NORMAL;
                    else if (cnt_q == MAX_LAST)
                        state_d = MODE_PROT;
                    else if ((cnt_q >= MIN_LAST) && !wr_active)
                        state_d = MODE_PROT;
                end
                MODE_PROT:  if (!trip) state_d = MODE_RECOV;
                MODE_BATT:  state_d = trip ? MODE_PROT : MODE_RECOV;
                MODE_RECOV: begin
                    if (trip)
                        state_d = MODE_PROT;
                    else if (cnt_q == REC_LAST)
                        state_d = MODE_NORMAL;
                end
                default: state_d = MODE_PROT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_NORMAL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (cnt_q != CNT_SAT)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mode     = state_q;
    assign batt_sel = (state_q == MODE_BATT);

    assert_pend_min_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == MODE_PEND && state_q == MODE_PROT) |-> ($past(cnt_q) >= MIN_LAST));

    assert_pend_max_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == MODE_PEND) |-> (cnt_q <= MAX_LAST));

    assert_batt_priority_R8: assert property (@(posedge clk) disable iff (rst)
        batt |=> (state_q == MODE_BATT));

    assert_batt_exit_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == MODE_BATT && state_q != MODE_BATT) |->
        (state_q == MODE_PROT || state_q == MODE_RECOV));

    assert_recov_len_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == MODE_RECOV && state_q == MODE_NORMAL) |-> ($past(cnt_q) == REC_LAST));
endmodule

// File: rtl/pwrfail_gate.sv
module pwrfail_gate
    import pwrfail_pkg::*;
(
    input  pwr_mode_e mode,
    input  ram_ctl_t  host,
    output ram_ctl_t  ram,
    output logic      drive
);
    logic open_q, sel, wr, rd;

    always_comb begin
        open_q = access_open(mode);
        sel    = open_q && !host.ce_n;
        wr     = sel && !host.we_n;
        rd     = sel && host.we_n && !host.oe_n;
        ram.ce_n = !sel;
        ram.we_n = !wr;
        ram.oe_n = !rd;
        drive    = rd;
    end
endmodule

// File: rtl/pwrfail_array.sv
module pwrfail_array #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     idx;

    always_comb begin
        idx = '0;
        for (int i = 0; i < ADDR_W; i++)
            idx[i % AW] = idx[i % AW] ^ addr[i];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
    import pwrfail_pkg::*;
#(
    parameter int PROT_MIN_CYC = 5000,
    parameter int PROT_MAX_CYC = 18750,
    parameter int REC_CYC      = 5000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sup_below_hi,
    input  logic              sup_below_lo,
    input  logic              sup_below_batt,
    input  logic              band_sel,
    input  logic              host_ce_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_drive,
    output logic              ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic              batt_sel,
    output logic [2:0]        mode
);
    sup_flags_t raw_f, syn_f;
    ram_ctl_t   host_c, ram_c;
    pwr_mode_e  mode_e;
    logic       trip_sel, drive;
    logic [DATA_W-1:0] arr_q;

    assign raw_f = '{batt: sup_below_batt, trip_lo: sup_below_lo, trip_hi: sup_below_hi};
    assign host_c = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

    pwrfail_sync #(.WIDTH($bits(sup_flags_t))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_f),
        .q   (syn_f)
    );

    assign trip_sel = band_sel ? syn_f.trip_lo : syn_f.trip_hi;

    pwrfail_seq #(
        .PROT_MIN_CYC (PROT_MIN_CYC),
        .PROT_MAX_CYC (PROT_MAX_CYC),
        .REC_CYC      (REC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .trip      (trip_sel),
        .batt      (syn_f.batt),
        .wr_active (!host_ce_n && !host_we_n),
        .mode      (mode_e),
        .batt_sel  (batt_sel)
    );

    pwrfail_gate u_gate (
        .mode  (mode_e),
        .host  (host_c),
        .ram   (ram_c),
        .drive (drive)
    );

    pwrfail_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AW(ARRAY_AW)) u_array (
        .clk   (clk),
        .wr_en (!ram_c.we_n),
        .addr  (addr),
        .wdata (dq_in),
        .rdata (arr_q)
    );

    assign ram_ce_n = ram_c.ce_n;
    assign ram_we_n = ram_c.we_n;
    assign ram_oe_n = ram_c.oe_n;
    assign dq_drive = drive;
    assign dq_out   = drive ? arr_q : '0;
    assign mode     = mode_e;

    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        (host_ce_n) |-> (ram_ce_n && ram_we_n && ram_oe_n && !dq_drive));

    assert_write_no_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (!ram_we_n) |-> (!dq_drive && ram_oe_n));

    assert_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_PROT || mode_e == MODE_BATT || mode_e == MODE_RECOV) |->
        (ram_ce_n && ram_we_n && ram_oe_n && !dq_drive));

    assert_battsel_R8: assert property (@(posedge clk) disable iff (rst)
        batt_sel |-> (mode == 3'd3));
endmodule

// File: tb/pwrfail_guard_test.sv
module pwrfail_guard_test;
    localparam int PMIN = 8;
    localparam int PMAX = 20;
    localparam int REC  = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi = 0, lo = 0, bt = 0, bsel = 0;
    logic ce_n = 1, oe_n = 1, we_n = 1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic dq_drive, ram_ce_n, ram_we_n, ram_oe_n, batt_sel;
    logic [2:0] mode;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwrfail_guard #(.PROT_MIN_CYC(PMIN), .PROT_MAX_CYC(PMAX), .REC_CYC(REC)) uut (
        .clk(clk), .rst(rst), .sup_below_hi(hi), .sup_below_lo(lo),
        .sup_below_batt(bt), .band_sel(bsel), .host_ce_n(ce_n),
        .host_oe_n(oe_n), .host_we_n(we_n), .addr(addr), .dq_in(din),
        .dq_out(dq_out), .dq_drive(dq_drive), .ram_ce_n(ram_ce_n),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .batt_sel(batt_sel),
        .mode(mode));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_st = 0, m_cnt = 0;
    bit p1h, p2h, p1l, p2l, p1b, p2b;
    logic [7:0] m_mem [1024];
    bit m_ok [1024];

    function automatic int fold(input logic [16:0] a);
        int r = 0;
        for (int i = 0; i < 17; i++) if (a[i]) r = r ^ (1 << (i % 10));
        return r;
    endfunction

    function automatic bit m_open();
        return (m_st == 0) || (m_st == 1);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0;
            p1h = 0; p2h = 0; p1l = 0; p2l = 0; p1b = 0; p2b = 0;
        end else begin
            int nst;
            bit trip, wr;
            trip = bsel ? p2l : p2h;
            wr = !ce_n && !we_n;
            nst = m_st;
            if (p2b) nst = 3;
            else if (m_st == 0) begin if (trip) nst = 1; end
            else if (m_st == 1) begin
                if (!trip) nst = 0;
                else if (m_cnt == PMAX - 1) nst = 2;
                else if (m_cnt >= PMIN - 1 && !wr) nst = 2;
            end
            else if (m_st == 2) begin if (!trip) nst = 4; end
            else if (m_st == 3) nst = trip ? 2 : 4;
            else begin
                if (trip) nst = 2;
                else if (m_cnt == REC - 1) nst = 0;
            end
            if (m_open() && wr) begin
                m_mem[fold(addr)] = din;
                m_ok[fold(addr)] = 1;
            end
            m_cnt = (nst != m_st) ? 0 : m_cnt + 1;
            m_st = nst;
            p2h = p1h; p1h = hi; p2l = p1l; p1l = lo; p2b = p1b; p1b = bt;
        end
    end

    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            bit sel, e_we, e_rd;
            sel  = m_open() && !ce_n;
            e_we = sel && !we_n;
            e_rd = sel && we_n && !oe_n;
            chk(mode == 3'(m_st), "R4 mode", mode, m_st);
            chk(ram_ce_n == !sel, "R1 ram_ce_n", ram_ce_n, !sel);
            chk(ram_we_n == !e_we, "R2 ram_we_n", ram_we_n, !e_we);
            chk(ram_oe_n == !e_rd, "R3 ram_oe_n", ram_oe_n, !e_rd);
            chk(dq_drive == e_rd, "R3 dq_drive", dq_drive, e_rd);
            chk(batt_sel == (m_st == 3), "R8 batt_sel", batt_sel, m_st == 3);
            if (e_rd && m_ok[fold(addr)])
                chk(dq_out == m_mem[fold(addr)], "R3 dq_out", dq_out, m_mem[fold(addr)]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic oe);
        addr = a; din = d; ce_n = 0; we_n = 0; oe_n = oe;
        #1;
        chk(ram_we_n == 0 && dq_drive == 0, "R2 write decode", {ram_we_n, dq_drive}, 0);
        tick(1); idle();
    endtask

    task automatic rd_expect(input logic [16:0] a, input logic [7:0] d, input string tag);
        addr = a; ce_n = 0; we_n = 1; oe_n = 0;
        #1;
        chk(dq_drive == 1 && dq_out == d, tag, dq_out, d);
        tick(1); idle();
    endtask

    task automatic mode_is(input int m, input string tag);
        #1;
        chk(mode == 3'(m), tag, mode, m);
    endtask

    initial begin
        tick(3);
        rst = 0;
        mode_is(0, "R4 reset mode");
        chk(batt_sel == 0, "R8 reset batt_sel", batt_sel, 0);
        chk(ram_ce_n == 1, "R1 reset ram_ce_n", ram_ce_n, 1);

        // normal decoding
        wr(17'h00005, 8'hA5, 1'b1);
        wr(17'h00010, 8'h3C, 1'b0);
        wr(17'h00400, 8'h77, 1'b1);
        rd_expect(17'h00005, 8'hA5, "R3 read back");
        rd_expect(17'h00010, 8'h3C, "R2 write with oe low");
        rd_expect(17'h00001, 8'h77, "R2 folded address");
        addr = 17'h00005; ce_n = 0; we_n = 1; oe_n = 1; #1;
        chk(dq_drive == 0 && dq_out == 0, "R3 oe high no drive", dq_drive, 0);
        tick(1);
        ce_n = 1; we_n = 0; oe_n = 0; #1;
        chk(ram_ce_n && ram_we_n && ram_oe_n && !dq_drive, "R1 ce high deselect", ram_we_n, 1);
        tick(1); idle();
        rd_expect(17'h00005, 8'hA5, "R1 no write while deselected");

        // trip with no write
        hi = 1;
        tick(2); mode_is(0, "R4 sync latency");
        tick(1); mode_is(1, "R5 enter pending");
        rd_expect(17'h00010, 8'h3C, "R5 access during pending");
        tick(PMIN - 2); mode_is(1, "R5 min window");
        tick(1); mode_is(2, "R5 protected");
        addr = 17'h00005; din = 8'hEE; ce_n = 0; we_n = 0; oe_n = 1; #1;
        chk(ram_we_n && ram_ce_n, "R7 write blocked", ram_we_n, 1);
        tick(2); idle();
        hi = 0;
        tick(3); mode_is(4, "R10 recovering");
        tick(REC - 1); mode_is(4, "R10 recovery length");
        tick(1); mode_is(0, "R10 normal again");
        rd_expect(17'h00005, 8'hA5, "R7 array untouched");

        // write held through whole window
        hi = 1; addr = 17'h00020; din = 8'h11; ce_n = 0; we_n = 0; oe_n = 1;
        tick(3 + PMAX - 1); mode_is(1, "R6 held by write");
        tick(1); mode_is(2, "R6 hard limit");
        idle(); hi = 0; tick(3 + REC + 1);

        // write ends between limits
        hi = 1; addr = 17'h00021; din = 8'h22; ce_n = 0; we_n = 0;
        tick(3 + PMIN + 2); mode_is(1, "R6 extended");
        idle();
        tick(1); mode_is(2, "R6 write ended");
        hi = 0; tick(3 + REC + 1);
        rd_expect(17'h00021, 8'h22, "R6 write completed");

        // battery priority and exits
        hi = 1; bt = 1;
        tick(3); mode_is(3, "R8 battery priority");
        chk(batt_sel == 1, "R8 batt_sel high", batt_sel, 1);
        bt = 0;
        tick(3); mode_is(2, "R9 batt exit to protected");
        chk(batt_sel == 0, "R8 batt_sel low", batt_sel, 0);
        bt = 1; tick(3); mode_is(3, "R8 re-enter battery");
        bt = 0; hi = 0;
        tick(3); mode_is(4, "R9 batt exit to recovery");
        tick(5); hi = 1;
        tick(3); mode_is(2, "R10 trip during recovery");
        hi = 0; tick(3 + REC + 1);
        mode_is(0, "R10 back to normal");

        // band select
        bsel = 1; hi = 1;
        tick(5); mode_is(0, "R11 unselected flag ignored");
        lo = 1;
        tick(3); mode_is(1, "R11 selected flag");
        lo = 0;
        tick(3); mode_is(0, "R5 trip cleared in pending");
        hi = 0; bsel = 0; tick(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule